// File: doc/BRIEF.md
# Regulator Control and Reset-Cause Register Block

This block is a small APB register slave. It sits between the bus and the analog power logic of a chip. Three 32-bit registers hold the settings for an on-chip voltage regulator and a brown-out detector, and report why the chip last came out of reset. The regulator settings leave the block as enable, high-impedance and 4-bit voltage-select outputs. The brown-out settings leave it as enable and 4-bit threshold outputs. A regulation-good status line from the regulator is brought into the clock domain and can be read back.

Three single-cycle event inputs report chip-level reset sources: power-on/brown-out, the external run pin, and a debugger-initiated restart. These events do not reset this block. It records them instead. A small cause state machine has the states CAUSE_NONE, CAUSE_POR, CAUSE_RUN and CAUSE_DBG. It leaves CAUSE_NONE only on an event. Any event moves it to the matching state, with the priority power-on > run pin > debugger. With no event it holds its state. A debugger restart also sets a sticky flag that software clears by writing a 1.

The bus side is a three-state machine:
- BUS_IDLE goes to BUS_ARMED on a setup phase.
- BUS_ARMED goes to BUS_DONE on the access phase, which is when the transfer commits.
- BUS_ARMED goes back to BUS_IDLE if the select drops.
- BUS_DONE goes to BUS_ARMED on a back-to-back setup, and otherwise to BUS_IDLE.

The only asynchronous reset is `presetn`, a cold reset. It clears everything.

Top module: `pwr_rst_regs`

## Requirements
- R1: After `presetn` the regulator register (offset 0x0) reads 0x000000B1 (bit 12 aside) and the brown-out register (offset 0x4) reads 0x00000091. The status register (offset 0x8) reads 0. The outputs match: vreg_en=1, vreg_hiz=0, vreg_vsel=0xB, bod_en=1, bod_vsel=0x9.
- R2: In the regulator register, bit 0 is enable, bit 1 is high-impedance and bits 7:4 are voltage select. A write commits at the access phase, and the outputs carry the new value from the next cycle.
- R3: In the brown-out register, bit 0 is enable and bits 7:4 are threshold select. A write drives bod_en and bod_vsel from the next cycle.
- R4: Only mask 0x10F3 (regulator), 0xF1 (brown-out) and 0x01110100 (status) is implemented. All other bits read 0 and ignore writes. Writes to the status register change nothing but the clear of bit 24.
- R5: Bit 12 of the regulator register is read-only. It shows `reg_ok_async` through a two-flop synchronizer, so a change is readable after the second rising clock edge that samples it.
- R6: Status bit 8 means the last recorded reset came from power-on/brown-out, bit 16 from the run pin, and bit 20 from a debugger restart. Any event cycle rewrites all three so that exactly one is set. Priority is power-on > run pin > debugger. Without events the bits hold.
- R7: A power-on/brown-out event restores both control registers to their reset values and clears bit 24. It also overrides a bus write in the same cycle.
- R8: Run-pin and debugger events leave the regulator and brown-out registers and outputs unchanged.
- R9: Status bit 24 is set by a debugger event unless a power-on event occurs in the same cycle. Writing 1 to it clears it and writing 0 has no effect. A debugger event in the same cycle as a clearing write leaves it set.
- R10: pready is always 1. pslverr is 1 only in the access phase of a transfer to an address other than 0x0, 0x4 or 0x8. Such a transfer changes no register. prdata is 0 except in the access phase of a read of a valid offset.
- R11: An access phase (psel=1, penable=1) that did not follow a setup phase commits no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Asynchronous active-low cold reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write direction |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 (no wait states) |
| pslverr | output | 1 | Error for unmapped offsets |
| ev_por | input | 1 | One-cycle pulse: power-on or brown-out reset occurred |
| ev_run | input | 1 | One-cycle pulse: run-pin reset occurred |
| ev_dbg | input | 1 | One-cycle pulse: debugger restart occurred |
| reg_ok_async | input | 1 | Asynchronous regulation-good status |
| vreg_en | output | 1 | Regulator enable |
| vreg_hiz | output | 1 | Regulator high-impedance mode |
| vreg_vsel | output | VSEL_W | Regulator output-voltage code |
| bod_en | output | 1 | Brown-out detector enable |
| bod_vsel | output | VSEL_W | Brown-out threshold code |

## Verification
The assertions take for granted that the reset-source events arrive as clean pulses synchronous to `pclk`. They also assume that a committed access phase is preceded by its setup phase. Under those assumptions they check cause priority, restoration on power-on, that the flag wins over a same-cycle clear, and that errors appear only in access phases.

The stimulus keeps every event to a single cycle and builds each transfer as setup then access. The one deliberate exception is a single orphaned access phase, driven to show that it commits nothing. Event collisions with writes are produced only by raising the event inside a normal access cycle.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;

    localparam int unsigned OFS_VREG = 0;
    localparam int unsigned OFS_BOD  = 4;
    localparam int unsigned OFS_STAT = 8;

    // bit positions software decodes
    localparam int unsigned VR_EN_BIT   = 0;
    localparam int unsigned VR_HIZ_BIT  = 1;
    localparam int unsigned VR_VSEL_LSB = 4;
    localparam int unsigned VR_ROK_BIT  = 12;
    localparam int unsigned BD_EN_BIT   = 0;
    localparam int unsigned BD_VSEL_LSB = 4;
    localparam int unsigned ST_POR_BIT  = 8;
    localparam int unsigned ST_RUN_BIT  = 16;
    localparam int unsigned ST_DBG_BIT  = 20;
    localparam int unsigned ST_FLAG_BIT = 24;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_ARMED,
        BUS_DONE
    } bus_state_e;

    typedef enum logic [1:0] {
        SEL_VREG,
        SEL_BOD,
        SEL_STAT,
        SEL_NONE
    } reg_sel_e;

    typedef enum logic [1:0] {
        CAUSE_NONE,
        CAUSE_POR,
        CAUSE_RUN,
        CAUSE_DBG
    } cause_e;

endpackage

// File: rtl/pwr_apb_fsm.sv
module pwr_apb_fsm
    import pwr_rst_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output reg_sel_e          sel_o,
    output logic              wr_o,
    output logic              rd_o,
    output logic              err_o
);

    bus_state_e state_q;
    bus_state_e state_d;
    logic       acc;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (psel && !penable) state_d = BUS_ARMED;
            end
            BUS_ARMED: begin
                if (psel && penable) state_d = BUS_DONE;
                else if (!psel)      state_d = BUS_IDLE;
            end
            BUS_DONE: begin
                if (psel && !penable) state_d = BUS_ARMED;
                else                  state_d = BUS_IDLE;
            end
            default: state_d = BUS_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        acc = (state_q == BUS_ARMED) && psel && penable;
        if (paddr == ADDR_W'(OFS_VREG))      sel_o = SEL_VREG;
        else if (paddr == ADDR_W'(OFS_BOD))  sel_o = SEL_BOD;
        else if (paddr == ADDR_W'(OFS_STAT)) sel_o = SEL_STAT;
        else                                 sel_o = SEL_NONE;
        wr_o  = acc && pwrite  && (sel_o != SEL_NONE);
        rd_o  = acc && !pwrite && (sel_o != SEL_NONE);
        err_o = acc && (sel_o == SEL_NONE);
    end

    AST_ERR_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (psel && penable)); // R10
    AST_WR_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_o |-> ($past(psel) && !$past(penable))); // R11

endmodule

// File: rtl/pwr_sync2.sv
module pwr_sync2 #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pwr_cause_track.sv
module pwr_cause_track
    import pwr_rst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ev_por_i,
    input  logic ev_run_i,
    input  logic ev_dbg_i,
    output logic had_por_o,
    output logic had_run_o,
    output logic had_dbg_o
);

    cause_e cause_q;
    cause_e cause_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cause_q <= CAUSE_NONE;
        end else begin
            cause_q <= cause_d;
        end
    end

    // fixed priority: power-on, then run pin, then debugger
    always_comb begin
        cause_d = cause_q;
        if (ev_por_i)      cause_d = CAUSE_POR;
        else if (ev_run_i) cause_d = CAUSE_RUN;
        else if (ev_dbg_i) cause_d = CAUSE_DBG;
    end

    always_comb begin
        had_por_o = 1'b0;
        had_run_o = 1'b0;
        had_dbg_o = 1'b0;
        unique case (cause_q)
            CAUSE_NONE: ;
            CAUSE_POR:  had_por_o = 1'b1;
            CAUSE_RUN:  had_run_o = 1'b1;
            CAUSE_DBG:  had_dbg_o = 1'b1;
            default:    ;
        endcase
    end

    AST_POR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_por_i |=> (had_por_o && !had_run_o && !had_dbg_o)); // R6
    AST_RUN_OVER_DBG: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_run_i && !ev_por_i) |=> (had_run_o && !had_dbg_o)); // R6
    AST_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_por_i || ev_run_i || ev_dbg_i) |=> $stable({had_por_o, had_run_o, had_dbg_o})); // R6

endmodule

// File: rtl/pwr_ctrl_regs.sv
module pwr_ctrl_regs
    import pwr_rst_pkg::*;
#(
    parameter int unsigned DATA_W       = 32,
    parameter int unsigned VSEL_W       = 4,
    parameter logic [VSEL_W-1:0] VR_VSEL_RST = 4'hB,
    parameter logic [VSEL_W-1:0] BD_VSEL_RST = 4'h9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  reg_sel_e          sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ev_por_i,
    input  logic              ev_dbg_i,
    output logic              vr_en_o,
    output logic              vr_hiz_o,
    output logic [VSEL_W-1:0] vr_vsel_o,
    output logic              bd_en_o,
    output logic [VSEL_W-1:0] bd_vsel_o,
    output logic              dbg_flag_o
);

    logic wr_vreg;
    logic wr_bod;
    logic clr_flag;

    assign wr_vreg  = wr_i && (sel_i == SEL_VREG);
    assign wr_bod   = wr_i && (sel_i == SEL_BOD);
    assign clr_flag = wr_i && (sel_i == SEL_STAT) && wdata_i[ST_FLAG_BIT];

    // regulator fields; power-on restores defaults ahead of any write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vr_en_o   <= 1'b1;
            vr_hiz_o  <= 1'b0;
            vr_vsel_o <= VR_VSEL_RST;
        end else if (ev_por_i) begin
            vr_en_o   <= 1'b1;
            vr_hiz_o  <= 1'b0;
            vr_vsel_o <= VR_VSEL_RST;
        end else if (wr_vreg) begin
            vr_en_o   <= wdata_i[VR_EN_BIT];
            vr_hiz_o  <= wdata_i[VR_HIZ_BIT];
            vr_vsel_o <= wdata_i[VR_VSEL_LSB +: VSEL_W];
        end
    end

    // brown-out fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bd_en_o   <= 1'b1;
            bd_vsel_o <= BD_VSEL_RST;
        end else if (ev_por_i) begin
            bd_en_o   <= 1'b1;
            bd_vsel_o <= BD_VSEL_RST;
        end else if (wr_bod) begin
            bd_en_o   <= wdata_i[BD_EN_BIT];
            bd_vsel_o <= wdata_i[BD_VSEL_LSB +: VSEL_W];
        end
    end

    // debugger flag: set beats clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dbg_flag_o <= 1'b0;
        end else if (ev_por_i) begin
            dbg_flag_o <= 1'b0;
        end else if (ev_dbg_i) begin
            dbg_flag_o <= 1'b1;
        end else if (clr_flag) begin
            dbg_flag_o <= 1'b0;
        end
    end

    AST_POR_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        ev_por_i |=> (vr_en_o && !vr_hiz_o && vr_vsel_o == VR_VSEL_RST
                      && bd_en_o && bd_vsel_o == BD_VSEL_RST && !dbg_flag_o)); // R7
    AST_SOFT_RESET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_por_i && !wr_i) |=> $stable({vr_en_o, vr_hiz_o, vr_vsel_o, bd_en_o, bd_vsel_o})); // R8
    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_dbg_i && !ev_por_i) |=> dbg_flag_o); // R9
    AST_FLAG_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_flag_o && !ev_por_i && !(wr_i && sel_i == SEL_STAT && wdata_i[ST_FLAG_BIT]))
        |=> dbg_flag_o); // R9

endmodule

// File: rtl/pwr_rst_regs.sv
module pwr_rst_regs
    import pwr_rst_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned VSEL_W      = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [31:0]       pwdata,
    output logic [31:0]       prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              ev_por,
    input  logic              ev_run,
    input  logic              ev_dbg,
    input  logic              reg_ok_async,
    output logic              vreg_en,
    output logic              vreg_hiz,
    output logic [VSEL_W-1:0] vreg_vsel,
    output logic              bod_en,
    output logic [VSEL_W-1:0] bod_vsel
);

    localparam int unsigned DATA_W = 32;

    reg_sel_e sel;
    logic     wr;
    logic     rd;
    logic     err;
    logic     rok_sync;
    logic     had_por;
    logic     had_run;
    logic     had_dbg;
    logic     dbg_flag;

    pwr_apb_fsm #(.ADDR_W(ADDR_W)) u_bus (
        .clk     (pclk),
        .rst_n   (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .sel_o   (sel),
        .wr_o    (wr),
        .rd_o    (rd),
        .err_o   (err)
    );

    pwr_sync2 #(.STAGES(SYNC_STAGES)) u_rok_sync (
        .clk     (pclk),
        .rst_n   (presetn),
        .d_async (reg_ok_async),
        .q_sync  (rok_sync)
    );

    pwr_cause_track u_cause (
        .clk       (pclk),
        .rst_n     (presetn),
        .ev_por_i  (ev_por),
        .ev_run_i  (ev_run),
        .ev_dbg_i  (ev_dbg),
        .had_por_o (had_por),
        .had_run_o (had_run),
        .had_dbg_o (had_dbg)
    );

    pwr_ctrl_regs #(
        .DATA_W (DATA_W),
        .VSEL_W (VSEL_W)
    ) u_regs (
        .clk        (pclk),
        .rst_n      (presetn),
        .wr_i       (wr),
        .sel_i      (sel),
        .wdata_i    (pwdata),
        .ev_por_i   (ev_por),
        .ev_dbg_i   (ev_dbg),
        .vr_en_o    (vreg_en),
        .vr_hiz_o   (vreg_hiz),
        .vr_vsel_o  (vreg_vsel),
        .bd_en_o    (bod_en),
        .bd_vsel_o  (bod_vsel),
        .dbg_flag_o (dbg_flag)
    );

    // read mux: zero outside a valid read access
    always_comb begin
        prdata = '0;
        if (rd) begin
            unique case (sel)
                SEL_VREG: begin
                    prdata[VR_EN_BIT]                 = vreg_en;
                    prdata[VR_HIZ_BIT]                = vreg_hiz;
                    prdata[VR_VSEL_LSB +: VSEL_W]     = vreg_vsel;
                    prdata[VR_ROK_BIT]                = rok_sync;
                end
                SEL_BOD: begin
                    prdata[BD_EN_BIT]                 = bod_en;
                    prdata[BD_VSEL_LSB +: VSEL_W]     = bod_vsel;
                end
                SEL_STAT: begin
                    prdata[ST_POR_BIT]                = had_por;
                    prdata[ST_RUN_BIT]                = had_run;
                    prdata[ST_DBG_BIT]                = had_dbg;
                    prdata[ST_FLAG_BIT]               = dbg_flag;
                end
                default: prdata = '0;
            endcase
        end
    end

    assign pready  = 1'b1;
    assign pslverr = err;

    AST_STATUS_ONEHOT: assert property (@(posedge pclk) disable iff (!presetn)
        $onehot0({had_por, had_run, had_dbg})); // R6
    AST_RDATA_QUIET: assert property (@(posedge pclk) disable iff (!presetn)
        !(psel && penable) |-> (prdata == '0)); // R10

endmodule

// File: tb/pwr_rst_regs_tb.sv
module pwr_rst_regs_tb;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic        ev_por = 1'b0;
    logic        ev_run = 1'b0;
    logic        ev_dbg = 1'b0;
    logic        reg_ok_async = 1'b0;
    logic        vreg_en;
    logic        vreg_hiz;
    logic [3:0]  vreg_vsel;
    logic        bod_en;
    logic [3:0]  bod_vsel;

    int    checks = 0;
    int    errs   = 0;
    bit    done   = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_vreg  = 'hB1;
    int m_bod   = 'h91;
    int m_cause = 0;    // 0 none, 1 power-on, 2 run pin, 3 debugger
    int m_flag  = 0;
    int m_s1    = 0;
    int m_s2    = 0;
    int m_armed = 0;

    pwr_rst_regs u_dut (
        .pclk (pclk), .presetn (presetn), .psel (psel), .penable (penable),
        .pwrite (pwrite), .paddr (paddr), .pwdata (pwdata), .prdata (prdata),
        .pready (pready), .pslverr (pslverr), .ev_por (ev_por), .ev_run (ev_run),
        .ev_dbg (ev_dbg), .reg_ok_async (reg_ok_async), .vreg_en (vreg_en),
        .vreg_hiz (vreg_hiz), .vreg_vsel (vreg_vsel), .bod_en (bod_en),
        .bod_vsel (bod_vsel)
    );

    always #5 pclk = ~pclk;

    function automatic bit addr_ok(input int a);
        return (a == 0) || (a == 4) || (a == 8);
    endfunction

    function automatic int read_value(input int a);
        int v;
        v = 0;
        if (a == 0) v = m_vreg | (m_s2 << 12);
        else if (a == 4) v = m_bod;
        else if (a == 8) v = ((m_cause == 1) << 8) | ((m_cause == 2) << 16)
                           | ((m_cause == 3) << 20) | (m_flag << 24);
        return v;
    endfunction

    // reference model update on each rising edge
    always @(posedge pclk) begin
        bit acc;
        acc = (m_armed != 0) && psel && penable;
        if (!presetn) begin
            m_vreg = 'hB1; m_bod = 'h91; m_cause = 0; m_flag = 0;
            m_s1 = 0; m_s2 = 0; m_armed = 0;
        end else begin
            if (ev_por) begin
                m_vreg = 'hB1; m_bod = 'h91; m_flag = 0;
            end else begin
                if (acc && pwrite && paddr == 0) m_vreg = pwdata & 'hF3;
                if (acc && pwrite && paddr == 4) m_bod  = pwdata & 'hF1;
                if (ev_dbg) m_flag = 1;
                else if (acc && pwrite && paddr == 8 && pwdata[24]) m_flag = 0;
            end
            if (ev_por)      m_cause = 1;
            else if (ev_run) m_cause = 2;
            else if (ev_dbg) m_cause = 3;
            m_s2 = m_s1;
            m_s1 = reg_ok_async;
            m_armed = (psel && !penable) ? 1 : 0;
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
        end
    endtask

    // compare every clock, between edges
    always @(negedge pclk) begin
        bit acc;
        #2;
        if (!done) begin
            acc = presetn && (m_armed != 0) && psel && penable;
            chk("vreg_en",   {31'd0, vreg_en},   m_vreg[0]);
            chk("vreg_hiz",  {31'd0, vreg_hiz},  m_vreg[1]);
            chk("vreg_vsel", {28'd0, vreg_vsel}, m_vreg[7:4]);
            chk("bod_en",    {31'd0, bod_en},    m_bod[0]);
            chk("bod_vsel",  {28'd0, bod_vsel},  m_bod[7:4]);
            chk("pready",    {31'd0, pready},    1);
            chk("pslverr",   {31'd0, pslverr},   (acc && !addr_ok(int'(paddr))) ? 1 : 0);
            chk("prdata",    prdata,
                (acc && !pwrite && addr_ok(int'(paddr))) ? read_value(int'(paddr)) : 0);
        end
    end

    // setup then access; optional events raised during the access cycle
    task automatic xfer(input bit wr, input int a, input logic [31:0] d,
                        input bit por = 0, input bit run = 0, input bit dbg = 0);
        @(negedge pclk);
        psel = 1; penable = 0; pwrite = wr; paddr = 12'(a); pwdata = d;
        @(negedge pclk);
        penable = 1; ev_por = por; ev_run = run; ev_dbg = dbg;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0; ev_por = 0; ev_run = 0; ev_dbg = 0;
    endtask

    task automatic pulse(input bit por, input bit run, input bit dbg);
        @(negedge pclk);
        ev_por = por; ev_run = run; ev_dbg = dbg;
        @(negedge pclk);
        ev_por = 0; ev_run = 0; ev_dbg = 0;
    endtask

    task automatic read_all();
        xfer(0, 0, 0);
        xfer(0, 4, 0);
        xfer(0, 8, 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge pclk);
        presetn = 1;
        read_all();

        cur_req = "R2";
        xfer(1, 0, 32'h0000_0052);
        xfer(0, 0, 0);
        xfer(1, 0, 32'h0000_00C1);
        xfer(0, 0, 0);

        cur_req = "R3";
        xfer(1, 4, 32'h0000_0030);
        xfer(0, 4, 0);
        xfer(1, 4, 32'h0000_00F1);

        cur_req = "R4";
        xfer(1, 0, 32'hFFFF_FFFF);
        xfer(0, 0, 0);
        xfer(1, 4, 32'hFFFF_FF0E);
        xfer(0, 4, 0);
        xfer(1, 8, 32'hFEFF_FFFF);
        xfer(0, 8, 0);

        cur_req = "R5";
        reg_ok_async = 1;
        xfer(0, 0, 0);
        repeat (2) @(negedge pclk);
        xfer(0, 0, 0);
        reg_ok_async = 0;
        xfer(0, 0, 0);

        cur_req = "R10";
        xfer(1, 12, 32'h0000_0000);
        xfer(0, 12, 0);
        xfer(1, 2, 32'h0000_0000);
        xfer(0, 'h100, 0);
        read_all();

        cur_req = "R11";
        @(negedge pclk);
        psel = 1; penable = 1; pwrite = 1; paddr = 0; pwdata = 32'h0000_0002;
        @(negedge pclk);
        psel = 0; penable = 0; pwrite = 0;
        xfer(0, 0, 0);

        cur_req = "R8";
        xfer(1, 0, 32'h0000_0062);
        pulse(0, 1, 0);
        read_all();
        pulse(0, 0, 1);
        read_all();

        cur_req = "R6";
        pulse(0, 1, 1);
        xfer(0, 8, 0);
        pulse(1, 1, 1);
        xfer(0, 8, 0);
        pulse(0, 0, 1);
        xfer(0, 8, 0);

        cur_req = "R9";
        xfer(1, 8, 32'h0000_0000);
        xfer(0, 8, 0);
        xfer(1, 8, 32'h0100_0000);
        xfer(0, 8, 0);
        pulse(0, 0, 1);
        xfer(1, 8, 32'h0100_0000, 0, 0, 1);
        xfer(0, 8, 0);

        cur_req = "R7";
        xfer(1, 4, 32'h0000_0020);
        xfer(1, 0, 32'h0000_0040, 1, 0, 0);
        read_all();
        xfer(1, 4, 32'h0000_0070);
        pulse(1, 0, 0);
        read_all();

        repeat (3) @(negedge pclk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule